// File: doc/BRIEF.md
# Flash Program/Erase Status Reporter

This block forms the word a host reads back from a flash array while an embedded program or erase runs, is suspended, or has ended. When no operation is pending the array word passes straight through. Otherwise the reporter replaces it with a status word carrying a polling bit (bit 7), an activity toggle (bit 6), a sticky failure flag (bit 5) and a sector toggle (bit 2). All other bits read 0. It also produces an open-drain-style busy pull-down, `rb_low`, which an outside pad turns into a wired ready/busy line.

A one-bit configuration selects between two readings of bit 7:
- Mode "00", the power-up value, is data polling.
- Mode "01" is a plain done flag. In this mode the status view also persists after success until an exit command.

The program address and the polling bit of the word being programmed enter over a small valid/ready load channel. `ld_ready` is low while an operation runs, so a load offered then waits. It is taken on the first edge where `ld_valid` and `ld_ready` are both high.

A host read is the interval in which `rd_en` (chip enable AND output enable) is high. `rd_data` is valid during that interval. The toggles advance once per read, when the read ends.

Top module: `flash_status_rpt`

## Requirements
- R1: After `pwr_rst_n` and `rst_n` the block is in array view: `rd_data` equals `arr_data`, `rb_low` is 0, `ld_ready` is 1, and the configuration is mode 00.
- R2: `cfg_wr` with `cfg_sel` (0 = mode 00, 1 = mode 01) sets the configuration. A write while an operation runs is ignored. A `rst_n` pulse leaves the configuration unchanged; only `pwr_rst_n` clears it.
- R3: `ld_ready` is 0 while an operation runs and 1 otherwise. An accepted load replaces the stored program address and polling bit.
- R4: In mode 00, during a program, a status read of the stored address returns the inverse of the stored polling bit on bit 7. Status reads of any other address, and all status reads during an erase, return 0 on bit 7.
- R5: In mode 01, bit 7 reads 0 while an operation runs and 1 once it has succeeded or failed.
- R6: Bit 6 holds a toggle shown on every status read. It inverts after each read made while an operation runs unsuspended or has failed. It holds still after a successful completion.
- R7: During an erase, bit 2 inverts after each read for which `sec_hit` is 1. Reads with `sec_hit` 0 leave it unchanged. During a program, bit 2 reads 1.
- R8: Bit 5 reads 0 while an operation runs. It reads 1 from the edge where `op_fail` is seen during a run and stays 1, whatever `op_active` does, until `id_exit`.
- R9: When `op_active` falls without failure, mode 00 returns to array view on the next edge. Mode 01 keeps the status view with bit 7 = 1 until `id_exit`. `id_exit` during a run is ignored. A failed operation needs `id_exit` in both modes.
- R10: While `suspend` is high during a run:
  - Reads with `sec_hit` 1 return bit 7 = 1, bit 6 = 1 and bit 5 = 0. Bit 2 toggles per R7 for an erase and reads 1 for a program.
  - Reads with `sec_hit` 0 return `arr_data`.
  - Bit 6 does not advance.
- R11: `rb_low` is 1 exactly while an operation runs and is not suspended. It drops on the edge after `op_active` falls or `op_fail` is seen.
- R12: Every bit of a status word other than 7, 6, 5 and 2 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Power-up reset, active low; clears configuration |
| rst_n | input | 1 | Functional reset, active low; configuration kept |
| op_active | input | 1 | Embedded operation in progress |
| op_kind | input | 1 | Operation type: 0 program, 1 erase (taken at start) |
| op_fail | input | 1 | Pulse-count limit exceeded or protected target |
| suspend | input | 1 | Running operation is suspended |
| id_exit | input | 1 | Exit command, leaves held status view |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Configuration value: 0 mode 00, 1 mode 01 |
| ld_valid | input | 1 | Program target offered |
| ld_ready | output | 1 | Program target can be accepted |
| ld_addr | input | ADDR_W | Address being programmed |
| ld_poll | input | 1 | Bit 7 of the word being programmed |
| rd_en | input | 1 | Host read active (chip enable AND output enable) |
| rd_addr | input | ADDR_W | Host read address |
| sec_hit | input | 1 | Read address lies in the operation's sector |
| arr_data | input | DATA_W | Word read from the array |
| rd_data | output | DATA_W | Word returned to the host |
| rb_low | output | 1 | Pull ready/busy line low |

## Verification
Some rules are checked as properties on every cycle:
- The configuration changes only after a write strobe.
- Bit 6 changes only after a read ends.
- The failure state and its bit 5 persist until `id_exit`.
- Mode 00 falls back to array view, and the busy pull-down lets go, one edge after a run ends.
- A held success view shows bit 7 = 1 with bit 5 clear.

Whole status words need the bench's scenarios. These cover bit 7 polling against the stored address, bit 2 advancing only on hits in the erased sector, suspend reads split by sector, and the configuration surviving a functional reset.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;
  typedef enum logic [1:0] {
    ST_ARRAY = 2'd0,
    ST_RUN   = 2'd1,
    ST_DONE  = 2'd2,
    ST_ERR   = 2'd3
  } fsr_state_e;

  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } fsr_op_e;

  localparam int BIT_POLL = 7;
  localparam int BIT_TOG  = 6;
  localparam int BIT_ERR  = 5;
  localparam int BIT_SEC  = 2;
endpackage

// File: rtl/fsr_mode_ctl.sv
`timescale 1ns/1ps
module fsr_mode_ctl
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              pwr_rst_n,
  input  logic              rst_n,
  input  logic              op_active,
  input  logic              op_kind,
  input  logic              op_fail,
  input  logic              id_exit,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              ld_poll,
  output fsr_state_e        st_q,
  output fsr_op_e           kind_q,
  output logic              cfg_q,
  output logic              ld_ready,
  output logic [ADDR_W-1:0] tgt_addr_q,
  output logic              tgt_poll_q
);
  logic running;
  assign running  = (st_q == ST_RUN);
  assign ld_ready = !running;

  // configuration survives the functional reset
  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n)                cfg_q <= 1'b0;
    else if (cfg_wr && !running)   cfg_q <= cfg_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_addr_q <= '0;
      tgt_poll_q <= 1'b0;
    end else if (ld_valid && ld_ready) begin
      tgt_addr_q <= ld_addr;
      tgt_poll_q <= ld_poll;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_ARRAY;
      kind_q <= OP_PROG;
    end else begin
      unique case (st_q)
        ST_ARRAY: if (op_active) begin
          st_q   <= ST_RUN;
          kind_q <= fsr_op_e'(op_kind);
        end
        ST_RUN: begin
          if (op_fail)         st_q <= ST_ERR;
          else if (!op_active) st_q <= cfg_q ? ST_DONE : ST_ARRAY;
        end
        ST_DONE, ST_ERR: if (id_exit) st_q <= ST_ARRAY;
        default: st_q <= ST_ARRAY;
      endcase
    end
  end
endmodule

// File: rtl/fsr_toggle.sv
`timescale 1ns/1ps
module fsr_toggle #(
  parameter int NUM = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_en,
  input  logic [NUM-1:0] adv,
  output logic [NUM-1:0] tog,
  output logic           rd_fall
);
  logic           rd_en_q;
  logic [NUM-1:0] adv_q;

  assign rd_fall = rd_en_q && !rd_en;

  // qualifiers are captured while the read is open, applied when it closes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_q <= 1'b0;
      adv_q   <= '0;
    end else begin
      rd_en_q <= rd_en;
      if (rd_en) adv_q <= adv;
    end
  end

  for (genvar i = 0; i < NUM; i++) begin : g_tog
    logic t_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  t_q <= 1'b0;
      else if (rd_fall && adv_q[i]) t_q <= !t_q;
    end
    assign tog[i] = t_q;
  end
endmodule

// File: rtl/fsr_word_mux.sv
`timescale 1ns/1ps
module fsr_word_mux
  import fsr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  fsr_state_e        st,
  input  logic              cfg01,
  input  fsr_op_e           kind,
  input  logic              suspend,
  input  logic              sec_hit,
  input  logic              addr_hit,
  input  logic              poll_bit,
  input  logic              tog_act,
  input  logic              tog_sec,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              adv_act,
  output logic              adv_sec,
  output logic              rb_low
);
  logic [DATA_W-1:0] stat;
  logic              use_stat;
  logic              erase;
  logic              poll_val;
  logic              sec_val;

  assign erase    = (kind == OP_ERASE);
  assign poll_val = (!erase && addr_hit) ? !poll_bit : 1'b0;
  assign sec_val  = erase ? tog_sec : 1'b1;
  assign rb_low   = (st == ST_RUN) && !suspend;

  always_comb begin
    stat     = '0;
    use_stat = 1'b0;
    adv_act  = 1'b0;
    adv_sec  = 1'b0;
    unique case (st)
      ST_RUN: begin
        if (suspend) begin
          if (sec_hit) begin
            use_stat        = 1'b1;
            stat[BIT_POLL]  = 1'b1;
            stat[BIT_TOG]   = 1'b1;
            stat[BIT_SEC]   = sec_val;
            adv_sec         = erase;
          end
        end else begin
          use_stat        = 1'b1;
          stat[BIT_POLL]  = cfg01 ? 1'b0 : poll_val;
          stat[BIT_TOG]   = tog_act;
          stat[BIT_SEC]   = sec_val;
          adv_act         = 1'b1;
          adv_sec         = erase && sec_hit;
        end
      end
      ST_ERR: begin
        use_stat        = 1'b1;
        stat[BIT_POLL]  = cfg01 ? 1'b1 : poll_val;
        stat[BIT_TOG]   = tog_act;
        stat[BIT_ERR]   = 1'b1;
        stat[BIT_SEC]   = sec_val;
        adv_act         = 1'b1;
        adv_sec         = erase && sec_hit;
      end
      ST_DONE: begin
        use_stat        = 1'b1;
        stat[BIT_POLL]  = 1'b1;
        stat[BIT_TOG]   = tog_act;
        stat[BIT_SEC]   = sec_val;
      end
      default: ;
    endcase
    rd_data = use_stat ? stat : arr_data;
  end
endmodule

// File: rtl/flash_status_rpt.sv
`timescale 1ns/1ps
module flash_status_rpt
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              pwr_rst_n,
  input  logic              rst_n,
  input  logic              op_active,
  input  logic              op_kind,
  input  logic              op_fail,
  input  logic              suspend,
  input  logic              id_exit,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              ld_poll,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              sec_hit,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rb_low
);
  localparam int NUM_TOG = 2;
  localparam int T_ACT   = 0;
  localparam int T_SEC   = 1;

  fsr_state_e        st_q;
  fsr_op_e           kind_q;
  logic              cfg_q;
  logic [ADDR_W-1:0] tgt_addr_q;
  logic              tgt_poll_q;
  logic [NUM_TOG-1:0] tog_vec;
  logic [NUM_TOG-1:0] adv_vec;
  logic              rd_fall;
  logic              addr_hit;

  assign addr_hit = (rd_addr == tgt_addr_q);

  fsr_mode_ctl #(.ADDR_W(ADDR_W)) u_mode (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .rst_n(rst_n),
    .op_active(op_active), .op_kind(op_kind), .op_fail(op_fail),
    .id_exit(id_exit), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_poll(ld_poll),
    .st_q(st_q), .kind_q(kind_q), .cfg_q(cfg_q), .ld_ready(ld_ready),
    .tgt_addr_q(tgt_addr_q), .tgt_poll_q(tgt_poll_q)
  );

  fsr_toggle #(.NUM(NUM_TOG)) u_tog (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en),
    .adv(adv_vec), .tog(tog_vec), .rd_fall(rd_fall)
  );

  fsr_word_mux #(.DATA_W(DATA_W)) u_mux (
    .st(st_q), .cfg01(cfg_q), .kind(kind_q), .suspend(suspend),
    .sec_hit(sec_hit), .addr_hit(addr_hit), .poll_bit(tgt_poll_q),
    .tog_act(tog_vec[T_ACT]), .tog_sec(tog_vec[T_SEC]),
    .arr_data(arr_data), .rd_data(rd_data),
    .adv_act(adv_vec[T_ACT]), .adv_sec(adv_vec[T_SEC]), .rb_low(rb_low)
  );
endmodule

// File: rtl/fsr_chk.sv
`timescale 1ns/1ps
module fsr_chk
  import fsr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              pwr_rst_n,
  input logic              rst_n,
  input logic              op_active,
  input logic              op_fail,
  input logic              id_exit,
  input logic              cfg_wr,
  input logic              rb_low,
  input logic [DATA_W-1:0] rd_data,
  input logic [1:0]        st,
  input logic              cfg,
  input logic              tog_act,
  input logic              rd_fall
);
  a_r2_cfg_only_on_write: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !$past(cfg_wr) |-> $stable(cfg));

  a_r6_toggle_on_read_end: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_act != $past(tog_act)) |-> $past(rd_fall));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERR && !id_exit) |=> (st == ST_ERR));

  a_r8_err_bit_shown: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERR) |-> rd_data[BIT_ERR]);

  a_r9_auto_return: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && !op_active && !op_fail && !cfg) |=> (st == ST_ARRAY));

  a_r11_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && (!op_active || op_fail)) |=> !rb_low);

  a_r5_done_word: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE) |-> (rd_data[BIT_POLL] && !rd_data[BIT_ERR]));
endmodule

bind flash_status_rpt fsr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .pwr_rst_n(pwr_rst_n), .rst_n(rst_n),
  .op_active(op_active), .op_fail(op_fail), .id_exit(id_exit),
  .cfg_wr(cfg_wr), .rb_low(rb_low), .rd_data(rd_data),
  .st(st_q), .cfg(cfg_q), .tog_act(tog_vec[T_ACT]), .rd_fall(rd_fall)
);

// File: tb/sim_flash_status_rpt.sv
`timescale 1ns/1ps
module sim_flash_status_rpt;
  localparam int AW = 19;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic pwr_rst_n, rst_n, op_active, op_kind, op_fail, suspend, id_exit;
  logic cfg_wr, cfg_sel, ld_valid, ld_ready, ld_poll, rd_en, sec_hit, rb_low;
  logic [AW-1:0] ld_addr, rd_addr;
  logic [DW-1:0] arr_data, rd_data;

  flash_status_rpt #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .rst_n(rst_n), .op_active(op_active),
    .op_kind(op_kind), .op_fail(op_fail), .suspend(suspend), .id_exit(id_exit),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_poll(ld_poll), .rd_en(rd_en), .rd_addr(rd_addr),
    .sec_hit(sec_hit), .arr_data(arr_data), .rd_data(rd_data), .rb_low(rb_low)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference state: 0 array, 1 run, 2 held success, 3 failed
  int       m_st = 0;
  logic     m_cfg = 0, m_kind = 0, m_t6 = 0, m_t2 = 0, m_poll = 0;
  logic [AW-1:0] m_addr = '0;

  function automatic logic [DW-1:0] arrv(logic [AW-1:0] a);
    return a[15:0] ^ 16'hA55A;
  endfunction

  assign arr_data = arrv(rd_addr);

  function automatic logic [DW-1:0] expw(logic [AW-1:0] a, logic sec, logic susp);
    logic [DW-1:0] w;
    logic pv, sv;
    w  = '0;
    pv = (!m_kind && a == m_addr) ? !m_poll : 1'b0;
    sv = m_kind ? m_t2 : 1'b1;
    case (m_st)
      1: begin
        if (susp) begin
          if (!sec) return arrv(a);
          w[7] = 1'b1; w[6] = 1'b1; w[2] = sv;
        end else begin
          w[7] = m_cfg ? 1'b0 : pv; w[6] = m_t6; w[2] = sv;
        end
      end
      2: begin w[7] = 1'b1; w[6] = m_t6; w[2] = sv; end
      3: begin w[7] = m_cfg ? 1'b1 : pv; w[6] = m_t6; w[5] = 1'b1; w[2] = sv; end
      default: return arrv(a);
    endcase
    return w;
  endfunction

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic sec, input string tag);
    logic a6, a2;
    @(negedge clk);
    rd_addr = a; sec_hit = sec; rd_en = 1'b1;
    @(negedge clk);
    chk(rd_data, expw(a, sec, suspend), tag);
    a6 = (m_st == 1 && !suspend) || m_st == 3;
    a2 = m_kind && sec && (m_st == 1 || m_st == 3);
    if (a6) m_t6 = !m_t6;
    if (a2) m_t2 = !m_t2;
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic v);
    @(negedge clk); cfg_wr = 1'b1; cfg_sel = v;
    @(negedge clk); cfg_wr = 1'b0;
    if (m_st != 1) m_cfg = v;
  endtask

  task automatic load(input logic [AW-1:0] a, input logic p);
    @(negedge clk); ld_valid = 1'b1; ld_addr = a; ld_poll = p;
    @(negedge clk); ld_valid = 1'b0;
    if (m_st != 1) begin m_addr = a; m_poll = p; end
  endtask

  task automatic start_op(input logic k);
    @(negedge clk); op_kind = k; op_active = 1'b1;
    @(negedge clk);
    if (m_st == 0) begin m_st = 1; m_kind = k; end
  endtask

  task automatic finish_ok();
    @(negedge clk); op_active = 1'b0;
    @(negedge clk);
    if (m_st == 1) m_st = m_cfg ? 2 : 0;
  endtask

  task automatic fail_op();
    @(negedge clk); op_fail = 1'b1;
    @(negedge clk); op_fail = 1'b0;
    if (m_st == 1) m_st = 3;
    @(negedge clk); op_active = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_exit();
    @(negedge clk); id_exit = 1'b1;
    @(negedge clk); id_exit = 1'b0;
    if (m_st == 2 || m_st == 3) m_st = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    pwr_rst_n = 0; rst_n = 0; op_active = 0; op_kind = 0; op_fail = 0;
    suspend = 0; id_exit = 0; cfg_wr = 0; cfg_sel = 0; ld_valid = 0;
    ld_addr = '0; ld_poll = 0; rd_en = 0; rd_addr = '0; sec_hit = 0;
    repeat (3) @(negedge clk);
    pwr_rst_n = 1; rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(DW'(rb_low), 16'd0, "R1 rb_low after reset");
    chk(DW'(ld_ready), 16'd1, "R1 ld_ready after reset");
    rd(19'h01234, 1'b0, "R1 array view after reset");

    // R4 mode 00 polling during program (default confirms R1 config)
    load(19'h00345, 1'b1);
    start_op(1'b0);
    chk(DW'(rb_low), 16'd1, "R11 busy while programming");
    chk(DW'(ld_ready), 16'd0, "R3 ld_ready low while running");
    rd(19'h00345, 1'b1, "R4 polled address read");
    rd(19'h00345, 1'b1, "R6 toggle advances on next read");
    rd(19'h00999, 1'b0, "R4 other address bit7 zero");
    set_cfg(1'b1);                       // R2 ignored while running
    @(negedge clk); id_exit = 1'b1; @(negedge clk); id_exit = 1'b0;  // R9 ignored
    rd(19'h00345, 1'b1, "R9 exit ignored while running");
    finish_ok();
    chk(DW'(rb_low), 16'd0, "R11 busy released on completion");
    rd(19'h00345, 1'b0, "R9 mode 00 auto return (R2 write ignored)");

    // R2 config kept over functional reset
    set_cfg(1'b1);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    m_t6 = 0; m_t2 = 0; m_addr = '0; m_poll = 0;
    load(19'h05000, 1'b0);
    chk(DW'(ld_ready), 16'd1, "R3 ld_ready in array view");
    start_op(1'b1);
    rd(19'h05001, 1'b1, "R5 mode 01 bit7 low while erasing (R2 kept)");
    rd(19'h05002, 1'b1, "R7 sector toggle advances on hit");
    rd(19'h70000, 1'b0, "R7 sector toggle held on miss");
    rd(19'h05003, 1'b1, "R7 sector toggle after miss");
    @(negedge clk); suspend = 1'b1; @(negedge clk);
    chk(DW'(rb_low), 16'd0, "R10 busy released while suspended");
    rd(19'h05004, 1'b1, "R10 suspended read of erased sector");
    rd(19'h05005, 1'b1, "R10 suspended sector toggle");
    rd(19'h60000, 1'b0, "R10 suspended read elsewhere is array");
    @(negedge clk); suspend = 1'b0;
    finish_ok();
    rd(19'h05006, 1'b1, "R5 mode 01 done bit7 high");
    rd(19'h05006, 1'b1, "R6 toggle frozen after success");
    do_exit();
    rd(19'h05006, 1'b1, "R9 exit returns to array");

    // R8 failure in mode 01 (program)
    load(19'h00777, 1'b0);
    start_op(1'b0);
    fail_op();
    chk(DW'(rb_low), 16'd0, "R11 busy released on failure");
    rd(19'h00777, 1'b0, "R8 fail bit set, R5 bit7 high");
    rd(19'h00777, 1'b0, "R8 fail sticky after op_active low");
    do_exit();
    rd(19'h00777, 1'b0, "R8 exit clears failure");

    // R9 failure in mode 00 needs exit too
    set_cfg(1'b0);
    load(19'h00888, 1'b0);
    start_op(1'b0);
    fail_op();
    rd(19'h00888, 1'b0, "R9 mode 00 failure holds status (R4 polled)");
    rd(19'h00111, 1'b0, "R12 status word other bits zero");
    do_exit();
    rd(19'h00888, 1'b0, "R9 mode 00 exit after failure");

    // constrained random operations
    for (int op = 0; op < 16; op++) begin
      logic k, f;
      set_cfg(1'($urandom % 2));
      load(AW'($urandom), 1'($urandom % 2));
      k = 1'($urandom % 2);
      f = ($urandom % 3) == 0;
      start_op(k);
      for (int r = 0; r < 10; r++) begin
        logic [AW-1:0] a;
        @(negedge clk); suspend = (($urandom % 4) == 0);
        a = ($urandom % 2) ? m_addr : AW'($urandom);
        rd(a, 1'($urandom % 2), "R6 R7 R10 random status read");
      end
      @(negedge clk); suspend = 1'b0;
      if (f) fail_op(); else finish_ok();
      rd(AW'($urandom), 1'($urandom % 2), "R8 R9 random end state");
      if (m_st != 0) do_exit();
      rd(AW'($urandom), 1'b0, "R1 random back to array");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule